// File: doc/BRIEF.md
# Decode-Stage Serialization Controller

This block sits beside an instruction decoder and lets the decoder run instructions that must execute in strict program order. While no such instruction is at the head of decode, instructions flow: the head is accepted for dispatch whenever the machine has room for one more in-flight instruction, and the decoder may keep advancing.

When a serializing instruction reaches the head of decode, the block stops decode at it and blocks dispatch. It keeps count of instructions that have been dispatched but have not yet retired, and waits for that count to reach zero. It then admits the serializing instruction alone, holds every younger instruction back until that one has retired, and then returns to free-flowing decode. A flush abandons any of these phases at once and clears the in-flight count.

The count is kept internally from the dispatch handshake (head valid and head ready in the same cycle) and a one-per-cycle retire strobe. The decoder's classification of which instructions serialize, and the retirement logic, are outside this block.

Top module: `decode_serializer`

## Requirements
- R1: After reset the block is in the free-flowing phase: `serial_busy_o` is 0, and with no instruction at the head `head_ready_o` and `decode_en_o` are both 1.
- R2: In the free-flowing phase a valid non-serializing head instruction sees `head_ready_o` = 1 and `decode_en_o` = 1, and is dispatched in that cycle.
- R3: When a valid head instruction has `instr_serial_i` = 1 in the free-flowing phase, `head_ready_o` and `decode_en_o` are 0 in that same cycle, and `serial_busy_o` is 1 from the next cycle on.
- R4: While older instructions remain in flight, `head_ready_o` and `decode_en_o` stay 0; the serializing instruction is first offered `head_ready_o` = 1 in the cycle after the retire that brings the in-flight count to zero.
- R5: In the phase where the serializing instruction may issue, `head_ready_o` is 1 only for a valid head with `instr_serial_i` = 1, `decode_en_o` is 0, and after that single dispatch `head_ready_o` is 0.
- R6: After the serializing instruction is dispatched, `head_ready_o` and `decode_en_o` stay 0 until it retires; in the cycle after that retire, `serial_busy_o` is 0 and `decode_en_o` is 1, also when the retire comes in the very first cycle of the wait.
- R7: A serializing instruction that arrives while nothing is in flight is offered `head_ready_o` = 1 in the next cycle.
- R8: With CNT_W counter bits, at most 2^CNT_W-1 instructions are in flight: at that count `head_ready_o` is 0, and it returns to 1 in the cycle after a retire.
- R9: A retire strobe while nothing is in flight is ignored and does not change the in-flight count.
- R10: A flush in any phase holds `head_ready_o` at 0 in that cycle; in the next cycle the block is in the free-flowing phase (`serial_busy_o` = 0) with an in-flight count of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Pipeline flush: abandon any phase, clear the in-flight count |
| instr_valid_i | input | 1 | An instruction is present at the head of decode |
| instr_serial_i | input | 1 | The head instruction is serializing |
| retire_i | input | 1 | One in-flight instruction retires this cycle |
| head_ready_o | output | 1 | Head instruction may dispatch; dispatch happens when valid and ready are both 1 |
| decode_en_o | output | 1 | Decoder may advance to younger instructions |
| serial_busy_o | output | 1 | A serialization sequence is in progress |

## Verification
The hardest situation to reach from the ports is the serializing instruction's retire landing in the first cycle after its own dispatch. That is the case where a late exit would deadlock the block or let a younger instruction slip through. The stimulus reaches it through the empty-pipeline path: it presents a serializing instruction with nothing in flight, dispatches it one cycle later, and raises the retire strobe in the very next cycle. The saturation and underflow cases of the hidden in-flight count are reached the same way. The bench fills the window to its limit, or sends a stray retire, and then infers the count from how many retires the drain phase waits for.

// File: rtl/dser_pkg.sv
package dser_pkg;

    typedef enum logic [1:0] {
        ST_FLOW  = 2'd0,
        ST_DRAIN = 2'd1,
        ST_ISSUE = 2'd2,
        ST_WAIT  = 2'd3
    } ser_state_e;

    typedef struct packed {
        ser_state_e state;
    } fsm_regs_t;

endpackage

// File: rtl/dser_inflight.sv
module dser_inflight #(
    parameter int CNT_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic inc_i,
    input  logic dec_i,
    output logic zero_o,
    output logic one_o,
    output logic full_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic             inc_ok, dec_ok;

    always_comb begin
        inc_ok = inc_i && (cnt_q != CNT_MAX);
        dec_ok = dec_i && (cnt_q != '0);
        cnt_d  = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else begin
            case ({inc_ok, dec_ok})
                2'b10:   cnt_d = cnt_q + CNT_ONE;
                2'b01:   cnt_d = cnt_q - CNT_ONE;
                default: cnt_d = cnt_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign zero_o = (cnt_q == '0);
    assign one_o  = (cnt_q == CNT_ONE);
    assign full_o = (cnt_q == CNT_MAX);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        full_o |-> !inc_i) else $error("dispatch accepted at full count"); // R8

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_o && dec_i && !inc_i && !clr_i) |=> zero_o) else $error("stray retire changed count"); // R9

    AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> zero_o) else $error("flush left count nonzero"); // R10

endmodule

// File: rtl/dser_fsm.sv
module dser_fsm
    import dser_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic flush_i,
    input  logic instr_valid_i,
    input  logic instr_serial_i,
    input  logic retire_i,
    input  logic cnt_zero_i,
    input  logic cnt_one_i,
    input  logic cnt_full_i,
    output logic head_ready_o,
    output logic decode_en_o,
    output logic serial_busy_o
);

    fsm_regs_t r_d, r_q;
    logic      serial_head;
    logic      drain_done;

    assign serial_head = instr_valid_i && instr_serial_i;
    // No dispatch happens in the phases that use this, so only retires move the count.
    assign drain_done  = cnt_zero_i || (cnt_one_i && retire_i);

    always_comb begin
        r_d = r_q;
        if (flush_i) begin
            r_d.state = ST_FLOW;
        end else begin
            case (r_q.state)
                ST_FLOW: begin
                    if (serial_head) begin
                        r_d.state = drain_done ? ST_ISSUE : ST_DRAIN;
                    end
                end
                ST_DRAIN: begin
                    if (drain_done) begin
                        r_d.state = ST_ISSUE;
                    end
                end
                ST_ISSUE: begin
                    if (serial_head) begin
                        r_d.state = ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (drain_done) begin
                        r_d.state = ST_FLOW;
                    end
                end
                default: r_d.state = ST_FLOW;
            endcase
        end
    end

    always_comb begin
        head_ready_o = 1'b0;
        decode_en_o  = 1'b0;
        case (r_q.state)
            ST_FLOW: begin
                head_ready_o = !flush_i && !cnt_full_i && !serial_head;
                decode_en_o  = !serial_head;
            end
            ST_ISSUE: begin
                head_ready_o = !flush_i && serial_head;
            end
            default: begin
                head_ready_o = 1'b0;
                decode_en_o  = 1'b0;
            end
        endcase
    end

    assign serial_busy_o = (r_q.state != ST_FLOW);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= ST_FLOW;
        end else begin
            r_q <= r_d;
        end
    end

    AST_ISSUE_NEEDS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_ISSUE) |-> cnt_zero_i) else $error("issue phase with older work in flight"); // R4

    AST_ISSUE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_ISSUE && serial_head && !flush_i) |=> (r_q.state == ST_WAIT && cnt_one_i)) else $error("serial dispatch not tracked"); // R5

    AST_WAIT_INFLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_WAIT) |-> !cnt_zero_i) else $error("waiting with nothing in flight"); // R6

    AST_WAIT_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_WAIT && cnt_one_i && retire_i && !flush_i) |=> !serial_busy_o) else $error("no resume after serial retire"); // R6

    AST_FLUSH_FLOW: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> !serial_busy_o) else $error("flush did not end serialization"); // R10

endmodule

// File: rtl/decode_serializer.sv
module decode_serializer #(
    parameter int CNT_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flush_i,
    input  logic instr_valid_i,
    input  logic instr_serial_i,
    input  logic retire_i,
    output logic head_ready_o,
    output logic decode_en_o,
    output logic serial_busy_o
);

    logic cnt_zero, cnt_one, cnt_full;
    logic dispatch_fire;

    assign dispatch_fire = instr_valid_i && head_ready_o;

    dser_inflight #(
        .CNT_W (CNT_W)
    ) u_inflight (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (flush_i),
        .inc_i  (dispatch_fire),
        .dec_i  (retire_i),
        .zero_o (cnt_zero),
        .one_o  (cnt_one),
        .full_o (cnt_full)
    );

    dser_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .flush_i        (flush_i),
        .instr_valid_i  (instr_valid_i),
        .instr_serial_i (instr_serial_i),
        .retire_i       (retire_i),
        .cnt_zero_i     (cnt_zero),
        .cnt_one_i      (cnt_one),
        .cnt_full_i     (cnt_full),
        .head_ready_o   (head_ready_o),
        .decode_en_o    (decode_en_o),
        .serial_busy_o  (serial_busy_o)
    );

    AST_BUSY_BLOCKS_YOUNGER: assert property (@(posedge clk) disable iff (!rst_n)
        (serial_busy_o && head_ready_o) |-> instr_serial_i) else $error("younger instruction dispatched during serialization"); // R5

endmodule

// File: tb/decode_serializer_bench.sv
module decode_serializer_bench;

    localparam int CNT_W    = 3;
    localparam int WIN_MAX  = (1 << CNT_W) - 1;
    localparam int WATCHDOG = 5000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flush_i = 1'b0;
    logic instr_valid_i = 1'b0;
    logic instr_serial_i = 1'b0;
    logic retire_i = 1'b0;
    logic head_ready_o, decode_en_o, serial_busy_o;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    decode_serializer #(.CNT_W(CNT_W)) u_decode_serializer (
        .clk            (clk),
        .rst_n          (rst_n),
        .flush_i        (flush_i),
        .instr_valid_i  (instr_valid_i),
        .instr_serial_i (instr_serial_i),
        .retire_i       (retire_i),
        .head_ready_o   (head_ready_o),
        .decode_en_o    (decode_en_o),
        .serial_busy_o  (serial_busy_o)
    );

    task automatic drive(input logic v, input logic s, input logic r, input logic f);
        @(negedge clk);
        instr_valid_i  = v;
        instr_serial_i = s;
        retire_i       = r;
        flush_i        = f;
        #2;
    endtask

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic t_reset();
        drive(0, 0, 0, 0);
        chk("R1", "serial_busy", serial_busy_o, 1'b0);
        chk("R1", "head_ready", head_ready_o, 1'b1);
        chk("R1", "decode_en", decode_en_o, 1'b1);
    endtask

    task automatic t_flow();
        drive(1, 0, 0, 0);
        chk("R2", "head_ready", head_ready_o, 1'b1);
        chk("R2", "decode_en", decode_en_o, 1'b1);
        drive(1, 0, 0, 0);
        chk("R2", "head_ready second", head_ready_o, 1'b1);
        drive(0, 0, 1, 0);
        drive(0, 0, 1, 0);
    endtask

    task automatic t_drain();
        drive(1, 0, 0, 0);
        drive(1, 0, 0, 0);
        drive(1, 1, 0, 0);
        chk("R3", "head_ready at arrival", head_ready_o, 1'b0);
        chk("R3", "decode_en at arrival", decode_en_o, 1'b0);
        drive(1, 1, 0, 0);
        chk("R3", "serial_busy", serial_busy_o, 1'b1);
        chk("R4", "head_ready draining", head_ready_o, 1'b0);
        drive(1, 1, 1, 0);
        chk("R4", "head_ready one left", head_ready_o, 1'b0);
        drive(1, 1, 1, 0);
        chk("R4", "head_ready last retire", head_ready_o, 1'b0);
        chk("R4", "decode_en draining", decode_en_o, 1'b0);
        drive(1, 1, 0, 0);
        chk("R4", "head_ready after drain", head_ready_o, 1'b1);
        chk("R5", "decode_en issue", decode_en_o, 1'b0);
        drive(1, 0, 0, 0);
        chk("R6", "head_ready waiting", head_ready_o, 1'b0);
        chk("R6", "decode_en waiting", decode_en_o, 1'b0);
        drive(1, 0, 0, 0);
        chk("R6", "head_ready still waiting", head_ready_o, 1'b0);
        drive(1, 0, 1, 0);
        chk("R6", "head_ready retire cycle", head_ready_o, 1'b0);
        drive(0, 0, 0, 0);
        chk("R6", "serial_busy after retire", serial_busy_o, 1'b0);
        chk("R6", "decode_en after retire", decode_en_o, 1'b1);
    endtask

    task automatic t_fast();
        drive(1, 1, 0, 0);
        chk("R7", "head_ready arrival", head_ready_o, 1'b0);
        drive(0, 0, 0, 0);
        chk("R5", "head_ready no head", head_ready_o, 1'b0);
        chk("R7", "serial_busy", serial_busy_o, 1'b1);
        drive(1, 0, 0, 0);
        chk("R5", "head_ready non-serial head", head_ready_o, 1'b0);
        drive(1, 1, 0, 0);
        chk("R7", "head_ready issue", head_ready_o, 1'b1);
        drive(1, 1, 1, 0);
        chk("R5", "head_ready after issue", head_ready_o, 1'b0);
        drive(0, 0, 0, 0);
        chk("R6", "serial_busy first-cycle retire", serial_busy_o, 1'b0);
        chk("R6", "decode_en first-cycle retire", decode_en_o, 1'b1);
    endtask

    task automatic t_full_flush();
        for (int i = 0; i < WIN_MAX; i++) begin
            drive(1, 0, 0, 0);
            chk("R8", "head_ready filling", head_ready_o, 1'b1);
        end
        drive(1, 0, 0, 0);
        chk("R8", "head_ready full", head_ready_o, 1'b0);
        drive(1, 0, 1, 0);
        chk("R8", "head_ready full retire cycle", head_ready_o, 1'b0);
        drive(0, 0, 0, 0);
        chk("R8", "head_ready after retire", head_ready_o, 1'b1);
        drive(0, 0, 0, 1);
        chk("R10", "head_ready flush", head_ready_o, 1'b0);
        drive(1, 1, 0, 0);
        chk("R10", "serial_busy after flush", serial_busy_o, 1'b0);
        drive(1, 1, 0, 0);
        chk("R10", "count cleared, fast issue", head_ready_o, 1'b1);
        drive(0, 0, 1, 0);
        drive(1, 0, 0, 0);
        drive(1, 1, 0, 0);
        drive(1, 1, 0, 0);
        chk("R10", "draining before flush", serial_busy_o, 1'b1);
        drive(1, 1, 0, 1);
        chk("R10", "head_ready flush in drain", head_ready_o, 1'b0);
        drive(0, 0, 0, 0);
        chk("R10", "serial_busy after drain flush", serial_busy_o, 1'b0);
        chk("R10", "decode_en after drain flush", decode_en_o, 1'b1);
    endtask

    task automatic t_stray_retire();
        drive(0, 0, 1, 0);
        drive(1, 0, 0, 0);
        drive(1, 1, 0, 0);
        drive(1, 1, 0, 0);
        chk("R9", "one still in flight", head_ready_o, 1'b0);
        drive(1, 1, 1, 0);
        drive(1, 1, 0, 0);
        chk("R9", "issue after one retire", head_ready_o, 1'b1);
        drive(0, 0, 1, 0);
        drive(0, 0, 0, 0);
        chk("R9", "serial_busy end", serial_busy_o, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_flow();
        t_drain();
        t_fast();
        t_full_flush();
        t_stray_retire();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule